// File: doc/BRIEF.md
# Wishbone SPI master controller

This block is a register-programmed SPI master that sits behind a classic Wishbone slave port. Software writes a transmit word, a clock divider and a mask of slave-select lines, and then writes the control register with the start bit set. The core drives a programmable number of bits on MOSI and samples MISO in the same transfer. The received bits land in the same storage that held the transmit word, so reading a data offset after a transfer returns what the slave sent.

The SPI mode is set by two independent bits rather than by polarity and phase. One bit picks the SCLK edge that updates MOSI, and the other picks the edge that samples MISO. The four classic modes map onto (drive-on-falling, sample-on-falling) as follows: mode 0 is (1,0), mode 1 is (0,1), mode 2 is (0,1) and mode 3 is (1,0). SCLK always rests low. Sixteen active-low select lines follow the select register, but only while a transfer runs. An address-translating bridge can place the five offsets anywhere in a larger map.

Top module: `spim_core`

## Requirements
- R1: Every clock in which cyc and stb are high and ack is low is answered by ack high in the next clock, for exactly one clock.
- R2: The byte offsets decode as follows: 0x00 is data bits 31:0, 0x04 is data bits 63:32, 0x10 is control, 0x14 is the clock divider (bits 7:0) and 0x18 is slave select (bits 15:0). Any other offset raises err together with ack, a write to it changes nothing, and a read from it returns zero.
- R3: Writing a data offset loads transmit bits. Reading a data offset returns the present contents of the shared 128-bit data storage, which holds the received bits once a transfer ends. Read data appears on the clock that carries ack, and is zero when no read is being answered.
- R4: The control register holds the length in bits 6:0, GO in bit 8, sample-on-falling in bit 9, drive-on-falling in bit 10 and LSB-first in bit 11. All other bits read zero. GO reads 1 while a transfer runs and reads 0 once it finishes.
- R5: SCLK is low whenever no transfer runs. Writing control with GO set while idle starts a transfer on the edge that accepts the write. Each SCLK half-period then lasts divider+1 bus clocks, the first rising edge comes divider+1 clocks after the start, and the transfer spans one SCLK period per bit.
- R6: With LSB-first clear the bits leave from position length-1 down to 0. With it set they leave from position 0 upward. MOSI shows the first bit from the start edge onward.
- R7: With drive-on-falling set, MOSI changes only on falling SCLK edges, moving to the next bit. With it clear, MOSI changes only on rising edges, moving to the bit of that SCLK period.
- R8: MISO is sampled on the falling edge when sample-on-falling is set, and on the rising edge otherwise. The sampled bit replaces the data bit sent in the same SCLK period. Bits at or above the length are left unchanged.
- R9: Select output k is low exactly when a transfer runs and bit k of the select register is 1.
- R10: While a transfer runs, writes to the data, control and divider offsets are acknowledged without err but have no effect. Writes to the select register take effect at any time.
- R11: A length field of 0 means 128 bits. Bits 64 to 127 are shifted like the others but cannot be reached through the bus.
- R12: A synchronous reset clears every register and the data storage, stops any transfer, drives all selects high and drives SCLK and MOSI low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and core clock |
| rst | input | 1 | Synchronous reset, active high |
| wb_cyc_i | input | 1 | Bus cycle active |
| wb_stb_i | input | 1 | Strobe for this access |
| wb_we_i | input | 1 | 1 for write, 0 for read |
| wb_adr_i | input | 5 | Byte offset of the register |
| wb_dat_i | input | 32 | Write data |
| wb_dat_o | output | 32 | Read data, valid with ack |
| wb_ack_o | output | 1 | Single-cycle acknowledge |
| wb_err_o | output | 1 | Access to an unimplemented offset, with ack |
| sclk_o | output | 1 | Serial clock, rests low |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| ss_n_o | output | 16 | Active-low slave selects |

## Verification
A wrong bit counter or a wrong length decode shows on the ports as a transfer that ends one SCLK period early or late. The selects and SCLK then disagree with the expected waveform on the first clock past the true end. A wrong position index shows on MOSI within one SCLK half-period of the bad bit. It can also corrupt a received bit, which stays hidden until the data is read back. The loopback run closes that gap, because any misplaced sample turns into a changed word. A divider counter that is off by one moves the first rising SCLK edge, so it shows within divider+2 clocks of the start.

// File: rtl/spim_pkg.sv
package spim_pkg;

  localparam int unsigned DW       = 32;
  localparam int unsigned ADR_W    = 5;
  localparam int unsigned LEN_W    = 7;
  localparam int unsigned MAX_BITS = 1 << LEN_W;
  localparam int unsigned CNT_W    = LEN_W + 1;

  // byte offsets seen by the bus
  localparam logic [ADR_W-1:0] OFS_DLO  = 5'h00;
  localparam logic [ADR_W-1:0] OFS_DHI  = 5'h04;
  localparam logic [ADR_W-1:0] OFS_CTRL = 5'h10;
  localparam logic [ADR_W-1:0] OFS_DIV  = 5'h14;
  localparam logic [ADR_W-1:0] OFS_SS   = 5'h18;

  // control bit positions
  localparam int unsigned CB_GO  = 8;
  localparam int unsigned CB_RXF = 9;
  localparam int unsigned CB_TXF = 10;
  localparam int unsigned CB_LSB = 11;

  typedef enum logic [2:0] {
    SEL_DLO, SEL_DHI, SEL_CTRL, SEL_DIV, SEL_SS, SEL_NONE
  } spim_sel_e;

  typedef struct packed {
    logic             lsb_first;
    logic             tx_fall;
    logic             rx_fall;
    logic [LEN_W-1:0] len;
  } spim_ctrl_t;

  function automatic spim_sel_e spim_decode(input logic [ADR_W-1:0] a);
    case (a)
      OFS_DLO:  return SEL_DLO;
      OFS_DHI:  return SEL_DHI;
      OFS_CTRL: return SEL_CTRL;
      OFS_DIV:  return SEL_DIV;
      OFS_SS:   return SEL_SS;
      default:  return SEL_NONE;
    endcase
  endfunction

  // length field 0 stands for the full storage width
  function automatic logic [CNT_W-1:0] spim_eff_len(input logic [LEN_W-1:0] f);
    return (f == '0) ? CNT_W'(MAX_BITS) : CNT_W'(f);
  endfunction

  // storage position of the bit sent in period idx
  function automatic logic [LEN_W-1:0] spim_bit_pos(input logic [CNT_W-1:0] idx,
                                                    input logic [CNT_W-1:0] eff,
                                                    input logic             lsb);
    logic [CNT_W-1:0] p;
    p = lsb ? idx : (eff - 1'b1 - idx);
    return p[LEN_W-1:0];
  endfunction

  function automatic spim_ctrl_t spim_ctrl_from_word(input logic [DW-1:0] w);
    spim_ctrl_t c;
    c.len       = w[LEN_W-1:0];
    c.rx_fall   = w[CB_RXF];
    c.tx_fall   = w[CB_TXF];
    c.lsb_first = w[CB_LSB];
    return c;
  endfunction

  function automatic logic [DW-1:0] spim_ctrl_word(input spim_ctrl_t c, input logic busy);
    logic [DW-1:0] w;
    w            = '0;
    w[LEN_W-1:0] = c.len;
    w[CB_GO]     = busy;
    w[CB_RXF]    = c.rx_fall;
    w[CB_TXF]    = c.tx_fall;
    w[CB_LSB]    = c.lsb_first;
    return w;
  endfunction

endpackage

// File: rtl/spim_clkgen.sv
module spim_clkgen #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             start,
  input  logic [DIV_W-1:0] div,
  output logic             sclk,
  output logic             rise_evt,
  output logic             fall_evt
);

  logic [DIV_W-1:0] cnt_q;
  logic             sclk_q;
  logic             tick;

  assign tick     = run & (cnt_q == '0);
  assign rise_evt = tick & ~sclk_q;
  assign fall_evt = tick & sclk_q;
  assign sclk     = sclk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else if (start) begin
      cnt_q  <= div;
      sclk_q <= 1'b0;
    end else if (tick) begin
      cnt_q  <= div;
      sclk_q <= ~sclk_q;
    end else if (run) begin
      cnt_q  <= cnt_q - 1'b1;
    end else begin
      sclk_q <= 1'b0;
    end
  end

endmodule

// File: rtl/spim_shifter.sv
module spim_shifter
  import spim_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  spim_ctrl_t    start_ctrl,
  input  spim_ctrl_t    ctrl,
  input  logic          rise_evt,
  input  logic          fall_evt,
  input  logic          miso,
  input  logic          ld_lo,
  input  logic          ld_hi,
  input  logic [DW-1:0] wdat,
  output logic          mosi,
  output logic          busy,
  output logic          done_evt,
  output logic [DW-1:0] word_lo,
  output logic [DW-1:0] word_hi
);

  logic [MAX_BITS-1:0] sr_q;
  logic [CNT_W-1:0]    bcnt_q;
  logic                busy_q;
  logic                mosi_q;

  logic [CNT_W-1:0]    eff;
  logic                last;
  logic [LEN_W-1:0]    cur_pos;
  logic [LEN_W-1:0]    nxt_pos;
  logic [LEN_W-1:0]    first_pos;
  logic                samp;
  logic                drv_now;
  logic                drv_next;

  assign eff       = spim_eff_len(ctrl.len);
  assign last      = (bcnt_q == eff - 1'b1);
  assign cur_pos   = spim_bit_pos(bcnt_q, eff, ctrl.lsb_first);
  assign nxt_pos   = spim_bit_pos(bcnt_q + 1'b1, eff, ctrl.lsb_first);
  assign first_pos = spim_bit_pos('0, spim_eff_len(start_ctrl.len), start_ctrl.lsb_first);

  assign samp     = busy_q & (ctrl.rx_fall ? fall_evt : rise_evt);
  assign drv_now  = busy_q & ~ctrl.tx_fall & rise_evt;
  assign drv_next = busy_q & ctrl.tx_fall & fall_evt & ~last;
  assign done_evt = busy_q & fall_evt & last;

  assign mosi    = mosi_q;
  assign busy    = busy_q;
  assign word_lo = sr_q[DW-1:0];
  assign word_hi = sr_q[2*DW-1:DW];

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q   <= '0;
      bcnt_q <= '0;
      busy_q <= 1'b0;
      mosi_q <= 1'b0;
    end else begin
      if (ld_lo) sr_q[DW-1:0]    <= wdat;
      if (ld_hi) sr_q[2*DW-1:DW] <= wdat;
      if (samp)  sr_q[cur_pos]   <= miso;
      if (start) begin
        busy_q <= 1'b1;
        bcnt_q <= '0;
        mosi_q <= sr_q[first_pos];
      end else begin
        if (drv_now)  mosi_q <= sr_q[cur_pos];
        if (drv_next) mosi_q <= sr_q[nxt_pos];
        if (busy_q && fall_evt) bcnt_q <= bcnt_q + 1'b1;
        if (done_evt) busy_q <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/spim_wb_regs.sv
module spim_wb_regs
  import spim_pkg::*;
#(
  parameter int unsigned SS_W  = 16,
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cyc,
  input  logic             stb,
  input  logic             we,
  input  logic [ADR_W-1:0] adr,
  input  logic [DW-1:0]    dat_i,
  output logic [DW-1:0]    dat_o,
  output logic             ack,
  output logic             err,
  input  logic             busy,
  input  logic [DW-1:0]    word_lo,
  input  logic [DW-1:0]    word_hi,
  output spim_ctrl_t       ctrl_q,
  output spim_ctrl_t       start_ctrl,
  output logic [DIV_W-1:0] div_q,
  output logic [SS_W-1:0]  ss_q,
  output logic             ld_lo,
  output logic             ld_hi,
  output logic             start_evt
);

  logic          ack_q;
  logic          err_q;
  logic [DW-1:0] dat_q;
  logic          acc;
  logic          bad;
  logic          wr;
  logic          ctrl_wr;
  logic          div_wr;
  logic          ss_wr;
  logic [DW-1:0] rdata;
  spim_sel_e     sel;

  assign sel        = spim_decode(adr);
  assign acc        = cyc & stb & ~ack_q;
  assign bad        = (sel == SEL_NONE);
  assign wr         = acc & we & ~bad;
  assign ld_lo      = wr & (sel == SEL_DLO) & ~busy;
  assign ld_hi      = wr & (sel == SEL_DHI) & ~busy;
  assign ctrl_wr    = wr & (sel == SEL_CTRL) & ~busy;
  assign div_wr     = wr & (sel == SEL_DIV) & ~busy;
  assign ss_wr      = wr & (sel == SEL_SS);
  assign start_ctrl = spim_ctrl_from_word(dat_i);
  assign start_evt  = ctrl_wr & dat_i[CB_GO];

  always_comb begin
    case (sel)
      SEL_DLO:  rdata = word_lo;
      SEL_DHI:  rdata = word_hi;
      SEL_CTRL: rdata = spim_ctrl_word(ctrl_q, busy);
      SEL_DIV:  rdata = DW'(div_q);
      SEL_SS:   rdata = DW'(ss_q);
      default:  rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_q  <= 1'b0;
      err_q  <= 1'b0;
      dat_q  <= '0;
      ctrl_q <= '0;
      div_q  <= '0;
      ss_q   <= '0;
    end else begin
      ack_q <= acc;
      err_q <= acc & bad;
      dat_q <= (acc & ~we & ~bad) ? rdata : '0;
      if (ctrl_wr) ctrl_q <= start_ctrl;
      if (div_wr)  div_q  <= dat_i[DIV_W-1:0];
      if (ss_wr)   ss_q   <= dat_i[SS_W-1:0];
    end
  end

  assign ack   = ack_q;
  assign err   = err_q;
  assign dat_o = dat_q;

endmodule

// File: rtl/spim_core.sv
module spim_core
  import spim_pkg::*;
#(
  parameter int unsigned SS_W  = 16,
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wb_cyc_i,
  input  logic             wb_stb_i,
  input  logic             wb_we_i,
  input  logic [ADR_W-1:0] wb_adr_i,
  input  logic [DW-1:0]    wb_dat_i,
  output logic [DW-1:0]    wb_dat_o,
  output logic             wb_ack_o,
  output logic             wb_err_o,
  output logic             sclk_o,
  output logic             mosi_o,
  input  logic             miso_i,
  output logic [SS_W-1:0]  ss_n_o
);

  spim_ctrl_t       ctrl_q;
  spim_ctrl_t       start_ctrl;
  logic [DIV_W-1:0] div_q;
  logic [SS_W-1:0]  ss_q;
  logic             ld_lo;
  logic             ld_hi;
  logic             start_evt;
  logic             rise_evt;
  logic             fall_evt;
  logic             done_evt;
  logic             busy;
  logic [DW-1:0]    word_lo;
  logic [DW-1:0]    word_hi;

  spim_wb_regs #(.SS_W(SS_W), .DIV_W(DIV_W)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .cyc        (wb_cyc_i),
    .stb        (wb_stb_i),
    .we         (wb_we_i),
    .adr        (wb_adr_i),
    .dat_i      (wb_dat_i),
    .dat_o      (wb_dat_o),
    .ack        (wb_ack_o),
    .err        (wb_err_o),
    .busy       (busy),
    .word_lo    (word_lo),
    .word_hi    (word_hi),
    .ctrl_q     (ctrl_q),
    .start_ctrl (start_ctrl),
    .div_q      (div_q),
    .ss_q       (ss_q),
    .ld_lo      (ld_lo),
    .ld_hi      (ld_hi),
    .start_evt  (start_evt)
  );

  spim_clkgen #(.DIV_W(DIV_W)) u_clkgen (
    .clk      (clk),
    .rst      (rst),
    .run      (busy),
    .start    (start_evt),
    .div      (div_q),
    .sclk     (sclk_o),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt)
  );

  spim_shifter u_shift (
    .clk        (clk),
    .rst        (rst),
    .start      (start_evt),
    .start_ctrl (start_ctrl),
    .ctrl       (ctrl_q),
    .rise_evt   (rise_evt),
    .fall_evt   (fall_evt),
    .miso       (miso_i),
    .ld_lo      (ld_lo),
    .ld_hi      (ld_hi),
    .wdat       (wb_dat_i),
    .mosi       (mosi_o),
    .busy       (busy),
    .done_evt   (done_evt),
    .word_lo    (word_lo),
    .word_hi    (word_hi)
  );

  // one gate per select line
  for (genvar g = 0; g < SS_W; g++) begin : g_ss
    assign ss_n_o[g] = ~(busy & ss_q[g]);
  end

endmodule

// File: rtl/spim_core_chk.sv
module spim_core_chk #(
  parameter int unsigned SS_W = 16
) (
  input logic            clk,
  input logic            rst,
  input logic            cyc,
  input logic            stb,
  input logic            ack,
  input logic            err,
  input logic            busy,
  input logic            sclk,
  input logic            mosi,
  input logic [SS_W-1:0] ss_n,
  input logic            rise_evt,
  input logic            fall_evt,
  input logic            done_evt,
  input logic            tx_fall
);

  assert_ack_pulse_R1: assert property (@(posedge clk) disable iff (rst)
    ack |=> !ack);

  assert_ack_follows_R1: assert property (@(posedge clk) disable iff (rst)
    (cyc && stb && !ack) |=> ack);

  assert_err_with_ack_R2: assert property (@(posedge clk) disable iff (rst)
    err |-> ack);

  assert_sclk_rest_R5: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !sclk);

  assert_sclk_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (busy && !rise_evt && !fall_evt) |=> $stable(sclk));

  assert_done_ends_R5: assert property (@(posedge clk) disable iff (rst)
    done_evt |=> (!busy && !sclk));

  assert_mosi_fall_R7: assert property (@(posedge clk) disable iff (rst)
    (busy && tx_fall && !fall_evt) |=> $stable(mosi));

  assert_mosi_rise_R7: assert property (@(posedge clk) disable iff (rst)
    (busy && !tx_fall && !rise_evt) |=> $stable(mosi));

  assert_ss_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (ss_n == {SS_W{1'b1}}));

endmodule

bind spim_core spim_core_chk #(.SS_W(SS_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cyc      (wb_cyc_i),
  .stb      (wb_stb_i),
  .ack      (wb_ack_o),
  .err      (wb_err_o),
  .busy     (busy),
  .sclk     (sclk_o),
  .mosi     (mosi_o),
  .ss_n     (ss_n_o),
  .rise_evt (rise_evt),
  .fall_evt (fall_evt),
  .done_evt (done_evt),
  .tx_fall  (ctrl_q.tx_fall)
);

// File: tb/spim_core_bench.sv
`timescale 1ns/1ps
module spim_core_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cyc = 1'b0, stb = 1'b0, we = 1'b0;
  logic [4:0]  adr = '0;
  logic [31:0] wdat = '0;
  wire  [31:0] rdat;
  wire         ack, err, sclk, mosi;
  wire  [15:0] ss_n;
  logic        loop = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  wire         miso = loop ? mosi : lfsr[0];

  always #4 clk = ~clk;

  spim_core u_spim_core (
    .clk(clk), .rst(rst), .wb_cyc_i(cyc), .wb_stb_i(stb), .wb_we_i(we),
    .wb_adr_i(adr), .wb_dat_i(wdat), .wb_dat_o(rdat), .wb_ack_o(ack),
    .wb_err_o(err), .sclk_o(sclk), .mosi_o(mosi), .miso_i(miso), .ss_n_o(ss_n)
  );

  int n_chk = 0, n_err = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) lfsr <= {lfsr[0] ^ lfsr[2] ^ lfsr[3] ^ lfsr[5], lfsr[15:1]};

  // behavioural reference model, advanced once per clock
  bit           m_live = 0, m_ack = 0, m_err = 0, m_sclk = 0, m_mosi = 0, m_busy = 0;
  logic [31:0]  m_dat = '0;
  logic [127:0] m_data = '0;
  logic [6:0]   m_lenf = '0;
  bit           m_lsb = 0, m_txf = 0, m_rxf = 0;
  int           m_len = 128, m_div = 0, m_el = 0;
  logic [15:0]  m_ss = '0;

  always @(posedge clk) begin : model
    bit acc, ob, nb, ns, nm, ack_n, err_n;
    logic [127:0] nd;
    logic [31:0] dat_n;
    int h, k, bi, p;
    if (rst) begin
      m_live = 1; m_ack = 0; m_err = 0; m_dat = '0; m_sclk = 0; m_mosi = 0;
      m_busy = 0; m_data = '0; m_lenf = '0; m_lsb = 0; m_txf = 0; m_rxf = 0;
      m_len = 128; m_div = 0; m_el = 0; m_ss = '0;
    end else begin
      acc = cyc && stb && !m_ack;
      ob = m_busy; nb = m_busy; ns = m_sclk; nm = m_mosi; nd = m_data;
      ack_n = acc; err_n = 0; dat_n = '0;
      if (ob) begin
        m_el++;
        h = m_div + 1;
        if (m_el % h == 0) begin
          k = m_el / h; bi = (k - 1) / 2;
          p = m_lsb ? bi : m_len - 1 - bi;
          if (k % 2 == 1) begin
            ns = 1;
            if (!m_rxf) nd[p] = miso;
            if (!m_txf) nm = m_data[p];
          end else begin
            ns = 0;
            if (m_rxf) nd[p] = miso;
            if (m_txf && bi + 1 < m_len) nm = m_data[m_lsb ? bi + 1 : m_len - 2 - bi];
            if (k == 2 * m_len) nb = 0;
          end
        end
      end
      if (acc) begin
        case (adr)
          5'h00: if (we) begin if (!ob) nd[31:0] = wdat; end else dat_n = m_data[31:0];
          5'h04: if (we) begin if (!ob) nd[63:32] = wdat; end else dat_n = m_data[63:32];
          5'h10: if (we) begin
                   if (!ob) begin
                     m_lenf = wdat[6:0]; m_rxf = wdat[9]; m_txf = wdat[10]; m_lsb = wdat[11];
                     m_len = (m_lenf == 0) ? 128 : int'(m_lenf);
                     if (wdat[8]) begin
                       nb = 1; m_el = 0; ns = 0;
                       nm = m_data[m_lsb ? 0 : m_len - 1];
                     end
                   end
                 end else dat_n = {20'b0, m_lsb, m_txf, m_rxf, ob, 1'b0, m_lenf};
          5'h14: if (we) begin if (!ob) m_div = int'(wdat[7:0]); end else dat_n = {24'b0, 8'(m_div)};
          5'h18: if (we) m_ss = wdat[15:0]; else dat_n = {16'b0, m_ss};
          default: err_n = 1;
        endcase
      end
      m_ack = ack_n; m_err = err_n; m_dat = dat_n;
      m_busy = nb; m_sclk = ns; m_mosi = nm; m_data = nd;
    end
  end

  // per-clock comparison against the model
  always @(negedge clk) if (m_live) begin
    check(ack === m_ack, "R1", "ack", 64'(ack), 64'(m_ack));
    check(err === m_err, "R2", "err", 64'(err), 64'(m_err));
    check(rdat === m_dat, "R3", "read data", 64'(rdat), 64'(m_dat));
    check(sclk === m_sclk, "R5", "sclk", 64'(sclk), 64'(m_sclk));
    check(mosi === m_mosi, "R6 R7", "mosi", 64'(mosi), 64'(m_mosi));
    check(ss_n === (m_busy ? ~m_ss : 16'hFFFF), "R9", "selects", 64'(ss_n),
          64'(m_busy ? ~m_ss : 16'hFFFF));
  end

  int   rises = 0;
  logic sclk_prev = 1'b0;
  always @(negedge clk) begin
    if (sclk === 1'b1 && sclk_prev === 1'b0) rises++;
    sclk_prev <= sclk;
  end

  task automatic bus(input bit w, input logic [4:0] a, input logic [31:0] d,
                     output logic [31:0] q, output bit e);
    @(negedge clk); cyc = 1; stb = 1; we = w; adr = a; wdat = d;
    @(negedge clk); q = rdat; e = err; cyc = 0; stb = 0; we = 0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    logic [31:0] q; bit e;
    bus(1, a, d, q, e);
  endtask

  task automatic rd_chk(input logic [4:0] a, input logic [31:0] exp, input string req);
    logic [31:0] q; bit e;
    bus(0, a, 32'h0, q, e);
    check(q === exp, req, "register read", 64'(q), 64'(exp));
  endtask

  task automatic wait_idle();
    while (m_busy) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    check(0, "R1", "watchdog expired", 64'd0, 64'd1);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin : stim
    logic [31:0] q; bit e;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 0;

    // R12: reset state of every register
    rd_chk(5'h10, 32'h0, "R12");
    rd_chk(5'h14, 32'h0, "R12");
    rd_chk(5'h18, 32'h0, "R12");
    rd_chk(5'h00, 32'h0, "R12");
    rd_chk(5'h04, 32'h0, "R12");

    // R4: field layout, unused bits read zero
    wr(5'h10, 32'hFFFF_FE7F);
    rd_chk(5'h10, 32'h0000_0E7F, "R4");
    wr(5'h10, 32'h0);

    // R2: unimplemented offsets
    bus(1, 5'h08, 32'h1234_5678, q, e);
    check(e === 1'b1, "R2", "err on write 0x08", 64'(e), 64'd1);
    bus(0, 5'h1C, 32'h0, q, e);
    check(e === 1'b1 && q === 32'h0, "R2", "err read 0x1C", 64'({e, q}), 64'({1'b1, 32'h0}));
    rd_chk(5'h00, 32'h0, "R2");

    // R3: data load and readback
    wr(5'h00, 32'hA5C3_0F96);
    wr(5'h04, 32'h1234_5678);
    rd_chk(5'h00, 32'hA5C3_0F96, "R3");
    rd_chk(5'h04, 32'h1234_5678, "R3");

    // mode 0, MSB first, 8 bits, divider 3
    wr(5'h14, 32'd3);
    wr(5'h18, 32'h0005);
    wr(5'h10, 32'h0000_0508);
    bus(0, 5'h10, 32'h0, q, e);
    check(q[8] === 1'b1, "R4", "GO while busy", 64'(q[8]), 64'd1);
    check(ss_n === 16'hFFFA, "R9", "selects during transfer", 64'(ss_n), 64'hFFFA);
    wr(5'h18, 32'h0003);
    check(ss_n === 16'hFFFC, "R10", "select write during transfer", 64'(ss_n), 64'hFFFC);
    wait_idle();
    rd_chk(5'h10, 32'h0000_0408, "R4");

    // drive rising, sample falling, 37 bits, divider 1
    wr(5'h14, 32'd1);
    wr(5'h10, 32'h0000_0325);
    wait_idle();

    // LSB first, 64 bits, divider 0
    wr(5'h14, 32'd0);
    wr(5'h10, 32'h0000_0D40);
    wait_idle();

    // R11: length 0 gives 128 SCLK periods
    rises = 0;
    wr(5'h10, 32'h0000_0700);
    wait_idle();
    check(rises == 128, "R11", "SCLK periods for length 0", 64'(rises), 64'd128);

    // R8 and R10: loopback keeps the word, busy writes ignored
    loop = 1;
    wr(5'h00, 32'h3C5A_96E1);
    wr(5'h14, 32'd2);
    wr(5'h10, 32'h0000_0520);
    wr(5'h00, 32'h0000_0000);
    wr(5'h10, 32'h0000_0000);
    wr(5'h14, 32'd7);
    wait_idle();
    rd_chk(5'h00, 32'h3C5A_96E1, "R8");
    rd_chk(5'h10, 32'h0000_0420, "R10");
    rd_chk(5'h14, 32'd2, "R10");
    loop = 0;

    // R12: reset in the middle of a transfer
    wr(5'h14, 32'd3);
    wr(5'h10, 32'h0000_0540);
    repeat (20) @(negedge clk);
    rst = 1;
    @(negedge clk);
    rst = 0;
    check(ss_n === 16'hFFFF && sclk === 1'b0 && mosi === 1'b0, "R12", "pins after reset",
          64'({ss_n, sclk, mosi}), 64'({16'hFFFF, 2'b00}));
    rd_chk(5'h10, 32'h0, "R12");
    rd_chk(5'h18, 32'h0, "R12");

    repeat (4) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule